// File: doc/BRIEF.md
# Forward AES Byte Substitution via Tower-Field Inversion

This block computes the forward AES substitution of one byte. The input byte is taken as an element of the AES field. A linear isomorphism carries it into a two-level tower field, GF(2^4) extended to degree two. There it is inverted using arithmetic on 4-bit halves. A single merged linear matrix then takes the inverse back to the AES field and applies the linear part of the affine step in the same pass. Adding the constant 0x63 completes the result.

The block has no state and no clock. A round datapath instantiates one copy for each byte lane it substitutes. The two conversion matrices are computed at elaboration from the field definitions, so no hand-typed table is involved. Each is built as a tree of XOR gates, one tree per output bit.

Top module: `sbox_fwd_tower`

## Requirements
- R1: For every input byte b, `sub_out` equals the inverse of b in GF(2^8) reduced by x^8+x^4+x^3+x+1 (with zero taken as its own inverse), passed through the AES affine map y_i = x_i ^ x_(i+4) ^ x_(i+5) ^ x_(i+6) ^ x_(i+7) (indices mod 8), then XORed with 0x63.
- R2: Input 0x00 yields 0x63.
- R3: Input 0x01 yields 0x7C.
- R4: The 256 inputs yield 256 distinct outputs.
- R5: No input maps to itself and no input maps to its bitwise complement.
- R6: The output follows a change of the input with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sub_in | input | 8 | Byte to substitute, in AES polynomial basis (bit 0 = coefficient of x^0) |
| sub_out | output | 8 | Substituted byte, same bit order |

## Verification
An error in the tower-field inverter or in either conversion matrix is not confined to a few inputs. It corrupts the output for most input bytes, and it shows on the output in the same evaluation as the input, because no state stands between them. The two known values, for 0x00 and 0x01, are a quick check that the zero path and the multiplicative identity map back correctly. The full sweep and the distinctness check catch a matrix that is singular or wrong in a single column.

// File: rtl/tf_pkg.sv
package tf_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;

  typedef logic [NIB_W-1:0]              nib_t;
  typedef logic [BYTE_W-1:0]             byte_t;
  typedef logic [BYTE_W-1:0][BYTE_W-1:0] mat8_t;  // [column] holds the image of basis bit column

  localparam byte_t AFFINE_ADD = 8'h63;

  // GF(2^4) product, reduction polynomial z^4 + z + 1
  function automatic nib_t gf16_mul(nib_t a, nib_t b);
    logic [2*NIB_W-2:0] p;
    p = '0;
    for (int i = 0; i < NIB_W; i++)
      if (b[i]) p ^= (7'(a) << i);
    for (int k = 2*NIB_W-2; k >= NIB_W; k--)
      if (p[k]) p ^= (7'b001_0011 << (k - NIB_W));
    return p[NIB_W-1:0];
  endfunction

  // a^14 = a^-1 for nonzero a; zero stays zero
  function automatic nib_t gf16_inv(nib_t a);
    nib_t a2, a4, a8;
    a2 = gf16_mul(a, a);
    a4 = gf16_mul(a2, a2);
    a8 = gf16_mul(a4, a4);
    return gf16_mul(gf16_mul(a8, a4), a2);
  endfunction

  // Smallest constant for which y^2 + y + c has no root in GF(2^4)
  function automatic nib_t find_lambda();
    nib_t res;
    logic done, has_root;
    res  = '0;
    done = 1'b0;
    for (int c = 1; c < 16; c++) begin
      has_root = 1'b0;
      for (int y = 0; y < 16; y++)
        if ((gf16_mul(nib_t'(y), nib_t'(y)) ^ nib_t'(y) ^ nib_t'(c)) == '0) has_root = 1'b1;
      if (!has_root && !done) begin
        res  = nib_t'(c);
        done = 1'b1;
      end
    end
    return res;
  endfunction

  localparam nib_t LAMBDA = find_lambda();

  // Tower product: element = {hi, lo} meaning hi*y + lo, y^2 = y + LAMBDA
  function automatic byte_t tower_mul(byte_t a, byte_t b);
    nib_t hh, hi, lo;
    hh = gf16_mul(a[7:4], b[7:4]);
    hi = hh ^ gf16_mul(a[7:4], b[3:0]) ^ gf16_mul(a[3:0], b[7:4]);
    lo = gf16_mul(hh, LAMBDA) ^ gf16_mul(a[3:0], b[3:0]);
    return {hi, lo};
  endfunction

  function automatic byte_t mat_apply(mat8_t m, byte_t x);
    byte_t r;
    r = '0;
    for (int c = 0; c < BYTE_W; c++)
      if (x[c]) r ^= m[c];
    return r;
  endfunction

  function automatic byte_t aes_affine_lin(byte_t x);
    byte_t r;
    for (int i = 0; i < BYTE_W; i++)
      r[i] = x[i] ^ x[(i+4)%8] ^ x[(i+5)%8] ^ x[(i+6)%8] ^ x[(i+7)%8];
    return r;
  endfunction

  // Columns are powers of a tower-field root of the AES reduction polynomial
  function automatic mat8_t build_in_map();
    mat8_t m;
    byte_t beta, p2, p3, p4, p8;
    logic  done;
    beta = 8'h02;
    done = 1'b0;
    for (int b = 2; b < 256; b++) begin
      p2 = tower_mul(byte_t'(b), byte_t'(b));
      p3 = tower_mul(p2, byte_t'(b));
      p4 = tower_mul(p2, p2);
      p8 = tower_mul(p4, p4);
      if (!done && ((p8 ^ p4 ^ p3 ^ byte_t'(b) ^ 8'h01) == '0)) begin
        beta = byte_t'(b);
        done = 1'b1;
      end
    end
    m[0] = 8'h01;
    for (int i = 1; i < BYTE_W; i++) m[i] = tower_mul(m[i-1], beta);
    return m;
  endfunction

  // Inverse of the input map, fused with the linear part of the affine step
  function automatic mat8_t build_out_map(mat8_t fwd);
    mat8_t m;
    byte_t pre;
    for (int j = 0; j < BYTE_W; j++) begin
      pre = '0;
      for (int a = 0; a < 256; a++)
        if (mat_apply(fwd, byte_t'(a)) == byte_t'(1 << j)) pre = byte_t'(a);
      m[j] = aes_affine_lin(pre);
    end
    return m;
  endfunction

  localparam mat8_t MAP_IN  = build_in_map();
  localparam mat8_t MAP_OUT = build_out_map(MAP_IN);
endpackage

// File: rtl/tf_linmap.sv
module tf_linmap
  import tf_pkg::*;
#(
  parameter mat8_t MAT = '0,
  parameter byte_t ADD = '0
) (
  input  logic [BYTE_W-1:0] vec_in,
  output logic [BYTE_W-1:0] vec_out
);
  for (genvar r = 0; r < BYTE_W; r++) begin : g_row
    logic [BYTE_W-1:0] sel;
    for (genvar c = 0; c < BYTE_W; c++) begin : g_col
      assign sel[c] = MAT[c][r];
    end
    assign vec_out[r] = (^(vec_in & sel)) ^ ADD[r];
  end
endmodule

// File: rtl/tf_gf16_inv.sv
module tf_gf16_inv
  import tf_pkg::*;
(
  input  logic [NIB_W-1:0] nib_in,
  output logic [NIB_W-1:0] nib_out
);
  always_comb nib_out = gf16_inv(nib_in);
endmodule

// File: rtl/tf_tower_inv.sv
module tf_tower_inv
  import tf_pkg::*;
(
  input  logic [BYTE_W-1:0] elem_in,
  output logic [BYTE_W-1:0] elem_out
);
  nib_t hi, lo, norm, norm_inv;

  always_comb begin
    hi   = elem_in[BYTE_W-1:NIB_W];
    lo   = elem_in[NIB_W-1:0];
    norm = gf16_mul(gf16_mul(hi, hi), LAMBDA) ^ gf16_mul(hi, lo) ^ gf16_mul(lo, lo);
  end

  tf_gf16_inv u_ninv (
    .nib_in (norm),
    .nib_out(norm_inv)
  );

  always_comb elem_out = {gf16_mul(hi, norm_inv), gf16_mul(hi ^ lo, norm_inv)};
endmodule

// File: rtl/sbox_fwd_tower.sv
module sbox_fwd_tower
  import tf_pkg::*;
(
  input  logic [7:0] sub_in,
  output logic [7:0] sub_out
);
  logic [BYTE_W-1:0] twr_val;
  logic [BYTE_W-1:0] twr_inv;

  tf_linmap #(.MAT(MAP_IN), .ADD(8'h00)) u_map_in (
    .vec_in (sub_in),
    .vec_out(twr_val)
  );

  tf_tower_inv u_inv (
    .elem_in (twr_val),
    .elem_out(twr_inv)
  );

  tf_linmap #(.MAT(MAP_OUT), .ADD(AFFINE_ADD)) u_map_out (
    .vec_in (twr_inv),
    .vec_out(sub_out)
  );
endmodule

// File: rtl/sbox_fwd_tower_chk.sv
module sbox_fwd_tower_chk
  import tf_pkg::*;
(
  input logic [7:0] sub_in,
  input logic [7:0] sub_out,
  input logic [7:0] twr_val,
  input logic [7:0] twr_inv
);
  always_comb begin
    if (!$isunknown({sub_in, sub_out, twr_val, twr_inv})) begin
      AST_TOWER_PRODUCT: assert ((twr_val == '0) || (tower_mul(twr_val, twr_inv) == 8'h01)); // R1
      AST_TOWER_ZERO: assert ((twr_val != '0) || (twr_inv == '0)); // R2
      AST_ZERO_BYTE: assert ((sub_in != '0) || (sub_out == 8'h63)); // R2
      AST_NO_FIXED: assert (sub_out != sub_in); // R5
      AST_NO_COMPL: assert (sub_out != ~sub_in); // R5
    end
  end
endmodule

bind sbox_fwd_tower sbox_fwd_tower_chk u_chk (
  .sub_in (sub_in),
  .sub_out(sub_out),
  .twr_val(twr_val),
  .twr_inv(twr_inv)
);

// File: tb/sim_sbox_fwd_tower.sv
`timescale 1ns/1ps
module sim_sbox_fwd_tower;
  logic clk;
  logic rst_n;
  logic [7:0] sub_in;
  logic [7:0] sub_out;
  int n_chk;
  int n_bad;
  logic finished;

  sbox_fwd_tower u0 (
    .sub_in (sub_in),
    .sub_out(sub_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  localparam logic [15:0] KNOWN [8] = '{
    16'h00_63, 16'h01_7C, 16'h02_77, 16'h03_7B,
    16'h10_CA, 16'h53_ED, 16'h80_CD, 16'hFF_16
  };

  function automatic logic [7:0] ref_mul(logic [7:0] a, logic [7:0] b);
    logic [7:0] r, x;
    r = '0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] ref_sbox(logic [7:0] v);
    logic [7:0] inv, r;
    inv = '0;
    for (int c = 1; c < 256; c++)
      if (ref_mul(v, 8'(c)) == 8'h01) inv = 8'(c);
    for (int i = 0; i < 8; i++)
      r[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
    return r ^ 8'h63;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: in=%02h actual=%02h expected=%02h", req, sub_in, act, exp);
    end
  endtask

  task automatic apply(logic [7:0] v);
    @(negedge clk);
    sub_in = v;
    #1;
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    sub_in = 8'h00;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // vector table
    for (int k = 0; k < 8; k++) begin
      apply(KNOWN[k][15:8]);
      check("R1 known", sub_out, KNOWN[k][7:0]);
    end

    // R1 full sweep against computed reference; R4 distinctness; R5 no fixed points
    begin
      logic [255:0] seen;
      seen = '0;
      for (int v = 0; v < 256; v++) begin
        apply(8'(v));
        check("R1", sub_out, ref_sbox(8'(v)));
        check("R4 distinct", {7'd0, seen[sub_out]}, 8'd0);
        seen[sub_out] = 1'b1;
        check("R5 fixed", {7'd0, sub_out == 8'(v)}, 8'd0);
        check("R5 complement", {7'd0, sub_out == ~8'(v)}, 8'd0);
      end
    end

    // R2 and R3 corner inputs
    apply(8'h00);
    check("R2", sub_out, 8'h63);
    apply(8'h01);
    check("R3", sub_out, 8'h7C);

    // R6: input change seen without any clock edge
    @(posedge clk);
    #1;
    sub_in = 8'h53;
    #1;
    check("R6", sub_out, 8'hED);
    sub_in = 8'hFF;
    #1;
    check("R6", sub_out, 8'h16);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule